// File: doc/BRIEF.md
# Idle/Sleep Wake-Up Controller

This block lets the processor fall into a light idle or sleep state and brings it back on a time-base event. The processor issues a one-cycle entry request. Unless a watchdog interrupt is already pending, the block switches off the processor clock enable. The time-base divider keeps running while the processor sleeps. Of the divider taps, the one chosen by a select input is watched through a synchroniser. Its first falling edge ends the sleep. Because the wake-up follows that edge and not the start of a full timer period, the first sleep can be shorter than the programmed interval.

At wake-up the block gives the clock back to the processor. It also says how execution continues. When the global interrupt enable, the time-base interrupt enable and the timer enable are all set, the time-base handler is started. In every other combination, the processor resumes at the instruction after the one that requested entry. The timer's interrupt latch is set on wake-up whenever the timer enable is on. The block also records whether the fast or the slow run mode was active at entry, so that the same mode is restored.

Top module: `idle_wake_ctrl`

## Requirements
- R1: After reset, `cpu_clk_en` is 1 and `asleep`, `wake_pulse`, `entry_abort`, `isr_start`, `resume_next`, `tb_irq_set` and `resume_slow` are all 0.
- R2: An entry request sampled while running, with no watchdog interrupt pending, drives `cpu_clk_en` to 0 and `asleep` to 1 from the next cycle on.
- R3: An entry request sampled while `wdt_irq_pend` is 1 is cancelled. `entry_abort` pulses for one cycle, and `cpu_clk_en` stays 1 with `asleep` staying 0.
- R4: While asleep, a falling edge on tap `tb_src[tb_sel]` wakes the block. The wake outputs appear SYNC_STAGES+1 clock edges after the edge is presented. Falling edges on other taps and rising edges do nothing.
- R5: `wake_pulse` is high for exactly one cycle per wake-up. In that same cycle `cpu_clk_en` returns to 1 and `asleep` returns to 0.
- R6: When `gie`, `tb_ie` and `tb_en` are all 1 at wake-up, `isr_start` pulses together with `wake_pulse` and `resume_next` stays 0.
- R7: When `gie`, `tb_ie` and `tb_en` are all 0 at wake-up, `resume_next` pulses together with `wake_pulse` and `isr_start` stays 0.
- R8: Any mixed setting of the three enables gives `resume_next` and no `isr_start`.
- R9: `tb_irq_set` pulses together with `wake_pulse` exactly when `tb_en` is 1 at wake-up.
- R10: `resume_slow` takes the value of `slow_active` at accepted entry. It holds that value while asleep, whatever `slow_active` does.
- R11: A falling edge on the selected tap while running produces no `wake_pulse` and leaves `cpu_clk_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle entry request from the processor |
| wdt_irq_pend | input | 1 | Watchdog interrupt pending |
| tb_src | input | NUM_TAPS | Time-base divider taps |
| tb_sel | input | SEL_W | Selected wake tap |
| tb_en | input | 1 | Time-base timer enable |
| gie | input | 1 | Global interrupt enable |
| tb_ie | input | 1 | Time-base interrupt enable |
| slow_active | input | 1 | 1 when the slow run mode is active |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| asleep | output | 1 | Idle/sleep state indicator |
| wake_pulse | output | 1 | One-cycle wake-up strobe |
| entry_abort | output | 1 | One-cycle strobe for an entry cancelled by the watchdog |
| isr_start | output | 1 | Start the time-base handler |
| resume_next | output | 1 | Resume at the instruction after entry |
| tb_irq_set | output | 1 | Set the time-base interrupt latch |
| resume_slow | output | 1 | Run mode to return to (1 = slow) |

## Verification
Each wake-up is tried with a different tap selected and a different mix of the three enables. This separates the all-on handler start and the all-off resume from the mixed cases, and it exposes an interrupt-latch output tied to the wrong enable. During each sleep, falling edges on non-selected taps and `slow_active` toggles are applied. These show whether the tap mux or the mode capture leaks. Directed cases cover the reset state, a watchdog-cancelled entry, and a selected-tap edge while running, which must not act as a wake-up.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;
   typedef enum logic {
      ST_RUN   = 1'b0,
      ST_SLEEP = 1'b1
   } wake_state_e;

   typedef struct packed {
      logic isr;
      logic resume;
      logic irq_set;
   } rel_kind_t;
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
   parameter int NUM_TAPS    = 4,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(NUM_TAPS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TAPS-1:0] tb_src,
   input  logic [SEL_W-1:0]    tb_sel,
   output logic                fall
);
   logic                   tap_bit;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   // tap mux: direct index when every code maps to a tap
   if ((2 ** SEL_W) == NUM_TAPS) begin : g_full_mux
      assign tap_bit = tb_src[tb_sel];
   end else begin : g_guarded_mux
      assign tap_bit = (tb_sel < SEL_W'(NUM_TAPS)) ? tb_src[tb_sel] : 1'b0;
   end

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b0;
         else if (s == 0) sync_q[s] <= tap_bit;
         else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign fall = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/wake_decide.sv
module wake_decide
   import idle_wake_pkg::*;
(
   input  logic      gie,
   input  logic      tb_ie,
   input  logic      tb_en,
   output rel_kind_t kind
);
   logic all_on;

   assign all_on       = gie & tb_ie & tb_en;
   assign kind.isr     = all_on;
   assign kind.resume  = ~all_on;
   assign kind.irq_set = tb_en;
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
   import idle_wake_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sleep_req,
   input  logic      wdt_irq_pend,
   input  logic      fall,
   input  logic      slow_active,
   input  rel_kind_t kind_in,
   output logic      cpu_clk_en,
   output logic      asleep,
   output logic      wake_pulse,
   output logic      entry_abort,
   output rel_kind_t kind_out,
   output logic      resume_slow
);
   wake_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_RUN;
         cpu_clk_en  <= 1'b1;
         wake_pulse  <= 1'b0;
         entry_abort <= 1'b0;
         kind_out    <= '0;
         resume_slow <= 1'b0;
      end else begin
         wake_pulse  <= 1'b0;
         entry_abort <= 1'b0;
         kind_out    <= '0;
         unique case (state_q)
            ST_RUN: begin
               if (sleep_req) begin
                  if (wdt_irq_pend) begin
                     entry_abort <= 1'b1;
                  end else begin
                     state_q     <= ST_SLEEP;
                     cpu_clk_en  <= 1'b0;
                     resume_slow <= slow_active;
                  end
               end
            end
            ST_SLEEP: begin
               if (fall) begin
                  state_q    <= ST_RUN;
                  cpu_clk_en <= 1'b1;
                  wake_pulse <= 1'b1;
                  kind_out   <= kind_in;
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign asleep = (state_q == ST_SLEEP);
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
   import idle_wake_pkg::*;
#(
   parameter int NUM_TAPS    = 4,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(NUM_TAPS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep_req,
   input  logic                wdt_irq_pend,
   input  logic [NUM_TAPS-1:0] tb_src,
   input  logic [SEL_W-1:0]    tb_sel,
   input  logic                tb_en,
   input  logic                gie,
   input  logic                tb_ie,
   input  logic                slow_active,
   output logic                cpu_clk_en,
   output logic                asleep,
   output logic                wake_pulse,
   output logic                entry_abort,
   output logic                isr_start,
   output logic                resume_next,
   output logic                tb_irq_set,
   output logic                resume_slow
);
   if (NUM_TAPS < 2) begin : g_bad_taps
      $error("idle_wake_ctrl: NUM_TAPS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("idle_wake_ctrl: SYNC_STAGES must be at least 2");
   end

   logic      fall;
   rel_kind_t kind_now;
   rel_kind_t kind_q;

   wake_edge_det #(
      .NUM_TAPS   (NUM_TAPS),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .tb_src(tb_src),
      .tb_sel(tb_sel),
      .fall  (fall)
   );

   wake_decide u_decide (
      .gie  (gie),
      .tb_ie(tb_ie),
      .tb_en(tb_en),
      .kind (kind_now)
   );

   wake_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_req),
      .wdt_irq_pend(wdt_irq_pend),
      .fall        (fall),
      .slow_active (slow_active),
      .kind_in     (kind_now),
      .cpu_clk_en  (cpu_clk_en),
      .asleep      (asleep),
      .wake_pulse  (wake_pulse),
      .entry_abort (entry_abort),
      .kind_out    (kind_q),
      .resume_slow (resume_slow)
   );

   assign isr_start   = kind_q.isr;
   assign resume_next = kind_q.resume;
   assign tb_irq_set  = kind_q.irq_set;
endmodule

// File: rtl/idle_wake_chk.sv
module idle_wake_chk (
   input logic clk,
   input logic rst_n,
   input logic sleep_req,
   input logic wdt_irq_pend,
   input logic cpu_clk_en,
   input logic asleep,
   input logic wake_pulse,
   input logic entry_abort,
   input logic isr_start,
   input logic resume_next,
   input logic tb_irq_set,
   input logic resume_slow
);
   a_r2_gate_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && sleep_req && !wdt_irq_pend) |=> (asleep && !cpu_clk_en));

   a_r3_wdt_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && sleep_req && wdt_irq_pend) |=> (entry_abort && cpu_clk_en && !asleep));

   a_r5_single_wake: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   a_r5_clock_back: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (cpu_clk_en && !asleep && $past(asleep)));

   a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $onehot({isr_start, resume_next}));

   a_r6_isr_with_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_start || resume_next) |-> wake_pulse);

   a_r9_latch_with_wake: assert property (@(posedge clk) disable iff (!rst_n)
      tb_irq_set |-> wake_pulse);

   a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && $past(asleep)) |-> $stable(resume_slow));

   a_r2_gated_when_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !cpu_clk_en);
endmodule

bind idle_wake_ctrl idle_wake_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_req   (sleep_req),
   .wdt_irq_pend(wdt_irq_pend),
   .cpu_clk_en  (cpu_clk_en),
   .asleep      (asleep),
   .wake_pulse  (wake_pulse),
   .entry_abort (entry_abort),
   .isr_start   (isr_start),
   .resume_next (resume_next),
   .tb_irq_set  (tb_irq_set),
   .resume_slow (resume_slow)
);

// File: tb/idle_wake_ctrl_tb.sv
module idle_wake_ctrl_tb;
   localparam int NUM_TAPS = 4;
   localparam int SEL_W    = 2;
   localparam int NVEC     = 5;

   // stimulus [9:4] = {gie, tb_ie, tb_en, slow, sel[1:0]}
   // expected [3:0] = {isr_start, resume_next, tb_irq_set, resume_slow}
   localparam logic [9:0] VEC [NVEC] = '{
      {6'b1110_00, 4'b1010},   // all on: handler (R6, R9)
      {6'b0001_01, 4'b0101},   // all off: resume (R7, R10)
      {6'b1010_10, 4'b0110},   // mixed (R8, R9)
      {6'b1101_11, 4'b0101},   // mixed, timer off (R8)
      {6'b0111_00, 4'b0111}    // mixed, slow mode (R8, R10)
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                sleep_req = 1'b0;
   logic                wdt_irq_pend = 1'b0;
   logic [NUM_TAPS-1:0] tb_src = '1;
   logic [SEL_W-1:0]    tb_sel = '0;
   logic                tb_en = 1'b0;
   logic                gie = 1'b0;
   logic                tb_ie = 1'b0;
   logic                slow_active = 1'b0;
   logic cpu_clk_en, asleep, wake_pulse, entry_abort;
   logic isr_start, resume_next, tb_irq_set, resume_slow;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   idle_wake_ctrl #(.NUM_TAPS(NUM_TAPS), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wdt_irq_pend(wdt_irq_pend),
      .tb_src(tb_src), .tb_sel(tb_sel), .tb_en(tb_en), .gie(gie), .tb_ie(tb_ie),
      .slow_active(slow_active), .cpu_clk_en(cpu_clk_en), .asleep(asleep),
      .wake_pulse(wake_pulse), .entry_abort(entry_abort), .isr_start(isr_start),
      .resume_next(resume_next), .tb_irq_set(tb_irq_set), .resume_slow(resume_slow)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic enter_sleep();
      @(negedge clk) sleep_req = 1'b1;
      @(negedge clk) sleep_req = 1'b0;
      chk("R2 asleep", asleep, 1'b1);
      chk("R2 cpu_clk_en", cpu_clk_en, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cpu_clk_en", cpu_clk_en, 1'b1);
      chk("R1 asleep", asleep, 1'b0);
      chk("R1 wake_pulse", wake_pulse, 1'b0);
      chk("R1 entry_abort", entry_abort, 1'b0);
      chk("R1 isr_start", isr_start, 1'b0);
      chk("R1 resume_next", resume_next, 1'b0);
      chk("R1 tb_irq_set", tb_irq_set, 1'b0);
      chk("R1 resume_slow", resume_slow, 1'b0);
      repeat (3) @(negedge clk);

      for (int v = 0; v < NVEC; v++) begin
         logic [5:0] st;
         logic [3:0] ex;
         int other;
         st = VEC[v][9:4];
         ex = VEC[v][3:0];
         gie = st[5]; tb_ie = st[4]; tb_en = st[3]; slow_active = st[2];
         tb_sel = st[1:0];
         other = (int'(tb_sel) + 1) % NUM_TAPS;
         enter_sleep();
         slow_active = ~st[2];                 // R10: ignored while asleep
         tb_src[other] = 1'b0;                 // R4: unselected tap falls
         repeat (5) begin
            @(negedge clk);
            chk("R4 unselected tap no wake", wake_pulse, 1'b0);
         end
         tb_src[other] = 1'b1;                 // R4: rising edge ignored
         repeat (4) @(negedge clk);
         chk("R4 still asleep", asleep, 1'b1);
         tb_src[tb_sel] = 1'b0;                // selected tap falls
         @(negedge clk);
         chk("R4 no early wake", wake_pulse, 1'b0);
         @(negedge clk);
         chk("R4 no early wake", wake_pulse, 1'b0);
         @(negedge clk);
         chk("R4 wake on selected fall", wake_pulse, 1'b1);
         chk("R5 clock back", cpu_clk_en, 1'b1);
         chk("R5 not asleep", asleep, 1'b0);
         chk("R6 isr_start", isr_start, ex[3]);
         chk("R7 resume_next", resume_next, ex[2]);
         chk("R9 tb_irq_set", tb_irq_set, ex[1]);
         chk("R10 resume_slow", resume_slow, ex[0]);
         @(negedge clk);
         chk("R5 single pulse", wake_pulse, 1'b0);
         chk("R6 isr pulse ends", isr_start, 1'b0);
         chk("R7 resume pulse ends", resume_next, 1'b0);
         tb_src[tb_sel] = 1'b1;
         repeat (4) @(negedge clk);
      end

      // R11: selected tap falls while running
      tb_sel = 2'd2;
      tb_src[2] = 1'b0;
      repeat (6) begin
         @(negedge clk);
         chk("R11 no wake while running", wake_pulse, 1'b0);
         chk("R11 clock stays on", cpu_clk_en, 1'b1);
      end
      tb_src[2] = 1'b1;
      repeat (4) @(negedge clk);

      // R3: watchdog pending cancels entry
      wdt_irq_pend = 1'b1;
      @(negedge clk) sleep_req = 1'b1;
      @(negedge clk) sleep_req = 1'b0;
      chk("R3 entry_abort", entry_abort, 1'b1);
      chk("R3 cpu_clk_en", cpu_clk_en, 1'b1);
      chk("R3 asleep", asleep, 1'b0);
      @(negedge clk);
      chk("R3 abort single", entry_abort, 1'b0);
      chk("R3 still running", asleep, 1'b0);
      wdt_irq_pend = 1'b0;

      // R2 after a cancel, a clean entry still works; then wake via tap 1
      tb_sel = 2'd1; gie = 1'b0; tb_ie = 1'b0; tb_en = 1'b0;
      enter_sleep();
      chk("R2 no abort", entry_abort, 1'b0);
      tb_src[1] = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 resume after clean entry", resume_next, 1'b1);
      tb_src[1] = 1'b1;
      repeat (2) @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule